// File: doc/BRIEF.md
# Quarter-Wave PWM Pattern Sequencer

This block turns a stream of single-cycle advance pulses into a two-level inverter pole gating signal. Each pulse moves a free-running phase counter forward by one step. The counter wraps naturally after a full electrical cycle, so the pulse rate alone sets the output frequency and the accumulated phase can never overflow.

The two top counter bits name the quadrant. The remaining bits are the angle inside that quadrant. The angle is folded into a single quarter-cycle index, and that index is joined with a 3-bit modulation index to address a quarter-wave pattern table of single-bit entries. The full cycle is then rebuilt from this quarter by mirroring the angle in alternate quadrants and inverting the level in the second half-cycle. A new modulation index is latched only when the phase wraps to zero, so a cycle is never built from two different patterns.

The table contents are computed at elaboration from a closed formula: a fixed-period carrier whose high width grows toward the quarter-cycle peak and with the modulation index.

Top module: `qwave_pattern_seq`

## Requirements
- R1: When `step_i` is high at a rising clock edge, the phase advances by exactly one. When `step_i` is low, the phase and `gate_o` hold their values.
- R2: The phase is 10 bits wide and wraps from 1023 to 0. The output sequence repeats exactly every 1024 steps.
- R3: Phase bits [9:8] form the quadrant q, and bits [7:0] form the in-quadrant angle a.
- R4: The folded table index d equals a in quadrants 1 and 3. It equals 255 − a (the bitwise complement) in quadrants 0 and 2.
- R5: In quadrants 2 and 3 the output is the inverse of the table entry. In quadrants 0 and 1 it equals the table entry.
- R6: For active modulation index m (0..7), the table entry T(d,m) is 1 exactly when (d mod 32) < 16 + (((m+1)·(255−d)) >> 7).
- R7: The active modulation index is loaded from `mod_idx_i` only on a step that wraps the phase to 0, or on a reset cycle. At any other time a change on `mod_idx_i` has no effect until the next wrap.
- R8: A synchronous active-high reset sets the phase to 0 and drives `gate_o` low on the next clock edge.
- R9: `gate_o` is registered. After the edge that moves the phase to p, it shows the level for phase p and the active index, with no further lag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | Phase advance pulse, one step per high cycle |
| mod_idx_i | input | 3 | Requested modulation index, latched at phase wrap |
| gate_o | output | 1 | Pole gating level, 1 = pole high |

## Verification
Each step pulse that is sampled at a rising edge produces its new gating level on that same edge, because the output register is loaded from the counter's next-state value. The bench therefore drives inputs on the falling edge and checks `gate_o` on the following falling edge, one edge after each stimulus. A modulation-index change is due only after the first wrap that follows it, so the bench model latches the index only when it wraps its own phase to 0. A reset is due on the edge it is sampled, so the bench checks for a low output and a restart at phase 0 at the next falling edge.

// File: rtl/qwp_pkg.sv
package qwp_pkg;

   // quadrant names along one electrical cycle
   typedef enum logic [1:0] {
      QD_RISE   = 2'd0,
      QD_PEAK   = 2'd1,
      QD_FALL   = 2'd2,
      QD_TROUGH = 2'd3
   } quad_e;

   // quarter-wave table entry: carrier of 2**cw positions, high width
   // grows from half a carrier period toward the quarter peak (d = 0)
   function automatic logic quarter_entry(input int d, input int m,
                                          input int aw, input int mw,
                                          input int cw);
      int amax;
      int half;
      int sh;
      int width;
      int pos;
      amax  = (1 << aw) - 1;
      half  = 1 << (cw - 1);
      sh    = aw + mw - cw + 1;
      width = half + (((m + 1) * (amax - d)) >>> sh);
      pos   = d & ((1 << cw) - 1);
      return (pos < width);
   endfunction

endpackage

// File: rtl/qwp_phase_counter.sv
module qwp_phase_counter #(
   parameter int PH_W = 10,
   parameter int MI_W = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            step_i,
   input  logic [MI_W-1:0] mod_i,
   output logic [PH_W-1:0] ph_nxt_o,
   output logic [MI_W-1:0] mod_nxt_o
);
   localparam logic [PH_W-1:0] PH_MAX = '1;
   localparam logic [PH_W-1:0] PH_ONE = {{(PH_W-1){1'b0}}, 1'b1};

   logic [PH_W-1:0] ph_q, ph_d;
   logic [MI_W-1:0] mod_q, mod_d;
   logic            wrap;

   always_comb begin
      wrap  = step_i && (ph_q == PH_MAX);
      ph_d  = step_i ? ph_q + PH_ONE : ph_q;
      mod_d = wrap ? mod_i : mod_q;
      if (rst) begin
         ph_d  = '0;
         mod_d = mod_i;
      end
   end

   always_ff @(posedge clk) begin
      ph_q  <= ph_d;
      mod_q <= mod_d;
   end

   assign ph_nxt_o  = ph_d;
   assign mod_nxt_o = mod_d;

   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !step_i |=> $stable(ph_q));                                   // R1
   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
      (step_i && ph_q != PH_MAX) |=> (ph_q == $past(ph_q) + PH_ONE)); // R1
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
      (step_i && ph_q == PH_MAX) |=> (ph_q == '0));                 // R2
   AST_MOD_LOCK: assert property (@(posedge clk) disable iff (rst)
      !(step_i && ph_q == PH_MAX) |=> $stable(mod_q));              // R7
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (ph_q == '0));                                        // R8

endmodule

// File: rtl/qwp_fold.sv
module qwp_fold #(
   parameter int PH_W = 10
) (
   input  logic [PH_W-1:0]  ph_i,
   output qwp_pkg::quad_e   quad_o,
   output logic [PH_W-3:0]  angle_o
);
   import qwp_pkg::*;

   logic [PH_W-3:0] low_field;

   always_comb begin
      quad_o    = quad_e'(ph_i[PH_W-1 -: 2]);
      low_field = ph_i[PH_W-3:0];
      // odd quadrants run forward, even quadrants run mirrored
      if (quad_o == QD_PEAK || quad_o == QD_TROUGH)
         angle_o = low_field;
      else
         angle_o = ~low_field;
   end

endmodule

// File: rtl/qwp_quarter_rom.sv
module qwp_quarter_rom #(
   parameter int AW        = 8,
   parameter int MI_W      = 3,
   parameter int CARRIER_W = 5
) (
   input  logic [AW-1:0]   angle_i,
   input  logic [MI_W-1:0] mod_i,
   output logic            bit_o
);
   localparam int NROW = 1 << MI_W;

   logic [NROW-1:0] row_bit;

   // one table column per modulation index
   for (genvar m = 0; m < NROW; m++) begin : g_row
      assign row_bit[m] = qwp_pkg::quarter_entry(int'(angle_i), m, AW,
                                                 MI_W, CARRIER_W);
   end

   always_comb begin
      bit_o = row_bit[mod_i];
   end

endmodule

// File: rtl/qwave_pattern_seq.sv
module qwave_pattern_seq #(
   parameter int PH_W      = 10,
   parameter int MI_W      = 3,
   parameter int CARRIER_W = 5
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            step_i,
   input  logic [MI_W-1:0] mod_idx_i,
   output logic            gate_o
);
   import qwp_pkg::*;

   localparam int AW = PH_W - 2;

   if (PH_W < 4) begin : g_bad_phase_width
      $error("qwave_pattern_seq: PH_W must be at least 4");
   end
   if (MI_W < 1) begin : g_bad_index_width
      $error("qwave_pattern_seq: MI_W must be at least 1");
   end
   if (CARRIER_W < 2 || CARRIER_W > AW || CARRIER_W - 1 > AW + MI_W) begin : g_bad_carrier
      $error("qwave_pattern_seq: CARRIER_W out of range");
   end

   logic [PH_W-1:0] ph_nxt;
   logic [MI_W-1:0] mod_nxt;
   quad_e           quad;
   logic [AW-1:0]   angle;
   logic            rom_bit;
   logic            level;
   logic            gate_q;

   qwp_phase_counter #(.PH_W(PH_W), .MI_W(MI_W)) u_counter (
      .clk      (clk),
      .rst      (rst),
      .step_i   (step_i),
      .mod_i    (mod_idx_i),
      .ph_nxt_o (ph_nxt),
      .mod_nxt_o(mod_nxt)
   );

   qwp_fold #(.PH_W(PH_W)) u_fold (
      .ph_i   (ph_nxt),
      .quad_o (quad),
      .angle_o(angle)
   );

   qwp_quarter_rom #(.AW(AW), .MI_W(MI_W), .CARRIER_W(CARRIER_W)) u_rom (
      .angle_i(angle),
      .mod_i  (mod_nxt),
      .bit_o  (rom_bit)
   );

   // second half-cycle is the negated first half
   always_comb begin
      if (quad == QD_FALL || quad == QD_TROUGH)
         level = ~rom_bit;
      else
         level = rom_bit;
   end

   always_ff @(posedge clk) begin
      if (rst) gate_q <= 1'b0;
      else     gate_q <= level;
   end

   assign gate_o = gate_q;

   AST_GATE_RESET: assert property (@(posedge clk)
      rst |=> !gate_o);                                             // R8
   AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!step_i && !$rose(rst)) |=> $stable(gate_o));                // R1

endmodule

// File: tb/qwave_pattern_seq_test.sv
module qwave_pattern_seq_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       step = 1'b0;
   logic [2:0] mod_in = 3'd3;
   logic       gate;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 0;

   int ph_m = 0;
   int mod_m = 0;

   always #10 clk = ~clk;   // 50 MHz

   qwave_pattern_seq uut (
      .clk      (clk),
      .rst      (rst),
      .step_i   (step),
      .mod_idx_i(mod_in),
      .gate_o   (gate)
   );

   // R3..R6: expected level from phase and active index
   function automatic logic exp_gate(input int p, input int m);
      int q, a, d, w;
      logic t;
      q = p / 256;
      a = p % 256;
      d = (q == 1 || q == 3) ? a : 255 - a;
      w = 16 + (((m + 1) * (255 - d)) / 128);
      t = ((d % 32) < w);
      return (q >= 2) ? ~t : t;
   endfunction

   function automatic string quad_tag(input int p);
      case (p / 256)
         0: return "R4";
         1: return "R3";
         2: return "R5";
         default: return "R6";
      endcase
   endfunction

   // called at a falling edge: drive, wait one cycle, check
   task automatic tick(input logic s, input string tag);
      logic e;
      string t;
      step = s;
      @(negedge clk);
      t = tag;
      if (rst) begin
         ph_m = 0;
         mod_m = int'(mod_in);
         e = 1'b0;
      end else begin
         if (s) begin
            ph_m = (ph_m + 1) % 1024;
            if (ph_m == 0) begin
               mod_m = int'(mod_in);
               t = "R2";
            end
         end
         e = exp_gate(ph_m, mod_m);
      end
      if (t == "") t = quad_tag(ph_m);
      checks++;
      if (gate !== e) begin
         failures++;
         $display("FAIL %s phase=%0d index=%0d actual=%0b expected=%0b",
                  t, ph_m, mod_m, gate, e);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // R8: output low while reset is held
      for (int i = 0; i < 3; i++) tick(1'b1, "R8");
      rst = 1'b0;

      // full cycles under every index (each takes effect at the next wrap)
      for (int m = 0; m < 8; m++) begin
         mod_in = 3'(m);
         for (int k = 0; k < 1024; k++) tick(1'b1, "");
      end
      for (int k = 0; k < 1024; k++) tick(1'b1, "");

      // R1: no step, phase and output hold
      for (int k = 0; k < 300; k++) tick(1'b1, "");
      for (int k = 0; k < 20; k++) tick(1'b0, "R1");

      // R7: index change mid-cycle is deferred until the wrap
      mod_in = 3'd6;
      while (ph_m != 1023) tick(1'b1, "R7");
      mod_in = 3'd1;
      for (int k = 0; k < 600; k++) tick(1'b1, "R7");

      // R9: isolated steps, each visible right after its edge
      for (int k = 0; k < 400; k++) tick(k % 3 == 0, "R9");

      // R8: reset in mid-cycle with a step requested
      mod_in = 3'd4;
      rst = 1'b1;
      tick(1'b1, "R8");
      rst = 1'b0;
      for (int k = 0; k < 1100; k++) tick(1'b1, "");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule